// File: doc/BRIEF.md
# Accumulator ALU with Register Operand

This block is the execute stage of a small 8-bit accumulator machine. Each executed instruction presents a 5-bit opcode, a 3-bit register select, the current accumulator, the value of the selected register and a valid strobe. One clock later the block returns the new accumulator, an optional value to write back into the selected register (with its enable and index), and four status flags.

Select 0 names a zero register. It does not simply read as zero. It turns each opcode into a variant of its own: a move becomes a clear, a store becomes a no-operation, and the unary register operations and the binary operand both act on the accumulator. Add-with-carry and subtract-with-borrow take their carry from a short history. That history holds the carry flag produced by the instruction two executed instructions earlier, so a multi-byte chain can put one unrelated instruction between its steps.

The surrounding machine owns the register file and the accumulator storage. It feeds the registered outputs back on the next instruction and applies the writeback when the enable is high.

Top module: `accu_alu`

## Requirements
- R1: After synchronous reset the accumulator output, writeback data, flags, `valid_o` and `wb_en_o` are all 0, and both carry history stages are 0.
- R2: Results appear one cycle after `valid_i`, with `valid_o` high for that cycle. In a cycle without `valid_i` the accumulator and flags hold their values, and `valid_o` and `wb_en_o` are low.
- R3: Opcode 5'h01 sets the accumulator to the register value. With select 0 it clears the accumulator.
- R4: Opcode 5'h02 sets the accumulator to the register value and writes the old accumulator back to the register. With select 0 it clears the accumulator and writes nothing. A writeback is never raised for select 0.
- R5: Opcode 5'h04 writes the accumulator into the selected register and leaves the accumulator unchanged. With select 0 it does nothing.
- R6: Opcodes 5'h05 (increment), 5'h06 (decrement), 5'h07 (two's-complement negate) and 5'h08 (logical right shift by one) operate on the register and return it through writeback, leaving the accumulator unchanged. With select 0 they operate on the accumulator instead.
- R7: Opcode 5'h09 adds the operand to the accumulator and 5'h0B subtracts it. The operand is the register, or the accumulator itself for select 0.
- R8: Opcode 5'h0A computes acc + reg + carry. Opcode 5'h0C computes acc - reg - 1 + carry. The carry is the C flag of the instruction issued two executed instructions earlier. With select 0, 5'h0A computes acc + carry and 5'h0C computes acc + 8'hFF + carry.
- R9: Opcodes 5'h0D, 5'h0E and 5'h0F OR, AND and XOR the operand into the accumulator. The operand is the accumulator itself for select 0.
- R10: Opcode 5'h00 with select 3 complements the accumulator. Opcode 5'h00 with any other select, opcode 5'h03 and every opcode 5'h10 to 5'h1F leave the accumulator unchanged, write nothing and produce C = U = 0.
- R11: Z is set when the resulting accumulator is 0 and S equals its bit 7. For arithmetic opcodes C is the carry out of bit 7; for subtractions C = 1 means no borrow. U is set when a subtract, subtract-with-borrow, decrement or negate borrows, and is 0 otherwise. C is 0 for non-arithmetic opcodes.
- R12: Every valid instruction shifts its own C into the carry history, non-arithmetic ones included (with C = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction executes this cycle |
| opcode_i | input | 5 | Instruction opcode |
| sel_i | input | SEL_W (3) | Register select, 0 is the zero register |
| acc_i | input | WIDTH (8) | Current accumulator |
| reg_i | input | WIDTH (8) | Value of the selected register |
| valid_o | output | 1 | Result valid |
| acc_o | output | WIDTH (8) | New accumulator |
| wb_en_o | output | 1 | Register writeback enable |
| wb_sel_o | output | SEL_W (3) | Register index to write |
| wb_data_o | output | WIDTH (8) | Register writeback value |
| flag_c_o | output | 1 | Carry out / no borrow |
| flag_s_o | output | 1 | Accumulator bit 7 |
| flag_z_o | output | 1 | Accumulator is zero |
| flag_u_o | output | 1 | Borrow (underflow) |

## Verification
The assertions assume that `acc_i`, `reg_i`, `sel_i` and `opcode_i` are stable and known whenever `valid_i` is high, and that reset is held for at least one clock edge. The bench drives every input on the falling edge and holds it through the rising edge. It lowers `valid_i` between groups, so the hold behaviour is both exercised and checked. Carry-chain cases are ordered so that the previous instruction's carry differs from the one two back, and a reset is placed inside the stream to show the history clears.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;

  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OP_MISC  = 5'h00;
  localparam logic [OPC_W-1:0] OP_LOAD  = 5'h01;
  localparam logic [OPC_W-1:0] OP_XCHG  = 5'h02;
  localparam logic [OPC_W-1:0] OP_STORE = 5'h04;
  localparam logic [OPC_W-1:0] OP_INC   = 5'h05;
  localparam logic [OPC_W-1:0] OP_DEC   = 5'h06;
  localparam logic [OPC_W-1:0] OP_NEG   = 5'h07;
  localparam logic [OPC_W-1:0] OP_RSH   = 5'h08;
  localparam logic [OPC_W-1:0] OP_ADD   = 5'h09;
  localparam logic [OPC_W-1:0] OP_ADDC  = 5'h0A;
  localparam logic [OPC_W-1:0] OP_SUB   = 5'h0B;
  localparam logic [OPC_W-1:0] OP_SUBB  = 5'h0C;
  localparam logic [OPC_W-1:0] OP_OR    = 5'h0D;
  localparam logic [OPC_W-1:0] OP_AND   = 5'h0E;
  localparam logic [OPC_W-1:0] OP_XOR   = 5'h0F;

  // select value that turns OP_MISC into accumulator complement
  localparam int MISC_NOT_SEL = 3;

  typedef enum logic [3:0] {
    K_NONE, K_LOAD, K_XCHG, K_STORE, K_ARITH,
    K_RSH, K_OR, K_AND, K_XOR, K_NOT
  } kind_e;

  typedef enum logic [1:0] {A_ACC, A_OPND, A_ZERO} asrc_e;
  typedef enum logic [1:0] {B_OPND, B_INV, B_ZERO, B_ONES} bsrc_e;
  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_HIST} csrc_e;

  typedef struct packed {
    kind_e kind;
    asrc_e a_src;
    bsrc_e b_src;
    csrc_e c_src;
    logic  subtract;  // U flag meaningful
    logic  to_reg;    // result returned through writeback
  } ctrl_t;

endpackage

// File: rtl/accu_alu_opdec.sv
module accu_alu_opdec
  import accu_alu_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [SEL_W-1:0] sel_i,
  output ctrl_t            ctrl_o
);

  logic zsel;
  assign zsel = (sel_i == '0);

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.kind     = K_NONE;
    ctrl_o.a_src    = A_ACC;
    ctrl_o.b_src    = B_OPND;
    ctrl_o.c_src    = CI_ZERO;
    ctrl_o.subtract = 1'b0;
    ctrl_o.to_reg   = 1'b0;
    case (opcode_i)
      OP_MISC:  ctrl_o.kind = (sel_i == SEL_W'(MISC_NOT_SEL)) ? K_NOT : K_NONE;
      OP_LOAD:  ctrl_o.kind = K_LOAD;
      OP_XCHG:  ctrl_o.kind = K_XCHG;
      OP_STORE: ctrl_o.kind = K_STORE;
      OP_INC: begin
        ctrl_o.kind = K_ARITH;  ctrl_o.a_src = A_OPND;
        ctrl_o.b_src = B_ZERO;  ctrl_o.c_src = CI_ONE;
        ctrl_o.to_reg = !zsel;
      end
      OP_DEC: begin
        ctrl_o.kind = K_ARITH;  ctrl_o.a_src = A_OPND;
        ctrl_o.b_src = B_ONES;  ctrl_o.subtract = 1'b1;
        ctrl_o.to_reg = !zsel;
      end
      OP_NEG: begin
        ctrl_o.kind = K_ARITH;  ctrl_o.a_src = A_ZERO;
        ctrl_o.b_src = B_INV;   ctrl_o.c_src = CI_ONE;
        ctrl_o.subtract = 1'b1; ctrl_o.to_reg = !zsel;
      end
      OP_RSH: begin
        ctrl_o.kind = K_RSH;    ctrl_o.to_reg = !zsel;
      end
      OP_ADD:  ctrl_o.kind = K_ARITH;
      OP_ADDC: begin
        ctrl_o.kind = K_ARITH;  ctrl_o.c_src = CI_HIST;
        ctrl_o.b_src = zsel ? B_ZERO : B_OPND;
      end
      OP_SUB: begin
        ctrl_o.kind = K_ARITH;  ctrl_o.b_src = B_INV;
        ctrl_o.c_src = CI_ONE;  ctrl_o.subtract = 1'b1;
      end
      OP_SUBB: begin
        ctrl_o.kind = K_ARITH;  ctrl_o.c_src = CI_HIST;
        ctrl_o.b_src = zsel ? B_ONES : B_INV;
        ctrl_o.subtract = 1'b1;
      end
      OP_OR:   ctrl_o.kind = K_OR;
      OP_AND:  ctrl_o.kind = K_AND;
      OP_XOR:  ctrl_o.kind = K_XOR;
      default: ctrl_o.kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/accu_alu_datapath.sv
module accu_alu_datapath
  import accu_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  ctrl_t            ctrl_i,
  input  logic             zsel_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic             hist_carry_i,
  output logic [WIDTH-1:0] acc_nx_o,
  output logic [WIDTH-1:0] wb_nx_o,
  output logic             wb_en_nx_o,
  output logic             c_nx_o,
  output logic             u_nx_o
);

  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] opnd, a_op, b_op, res;
  logic             cin;
  logic [SUM_W-1:0] sum;

  assign opnd = zsel_i ? acc_i : reg_i;

  always_comb begin
    case (ctrl_i.a_src)
      A_OPND:  a_op = opnd;
      A_ZERO:  a_op = '0;
      default: a_op = acc_i;
    endcase
    case (ctrl_i.b_src)
      B_INV:   b_op = ~opnd;
      B_ZERO:  b_op = '0;
      B_ONES:  b_op = '1;
      default: b_op = opnd;
    endcase
    case (ctrl_i.c_src)
      CI_ONE:  cin = 1'b1;
      CI_HIST: cin = hist_carry_i;
      default: cin = 1'b0;
    endcase
  end

  assign sum = {1'b0, a_op} + {1'b0, b_op} + SUM_W'(cin);

  always_comb begin
    acc_nx_o   = acc_i;
    wb_nx_o    = '0;
    wb_en_nx_o = 1'b0;
    c_nx_o     = 1'b0;
    u_nx_o     = 1'b0;
    res        = '0;
    case (ctrl_i.kind)
      K_LOAD:  acc_nx_o = zsel_i ? '0 : reg_i;
      K_XCHG: begin
        acc_nx_o   = zsel_i ? '0 : reg_i;
        wb_nx_o    = acc_i;
        wb_en_nx_o = !zsel_i;
      end
      K_STORE: begin
        wb_nx_o    = acc_i;
        wb_en_nx_o = !zsel_i;
      end
      K_ARITH, K_RSH: begin
        if (ctrl_i.kind == K_ARITH) begin
          res    = sum[WIDTH-1:0];
          c_nx_o = sum[WIDTH];
          u_nx_o = ctrl_i.subtract & ~sum[WIDTH];
        end else begin
          res = {1'b0, opnd[WIDTH-1:1]};
        end
        if (ctrl_i.to_reg) begin
          wb_nx_o    = res;
          wb_en_nx_o = 1'b1;
        end else begin
          acc_nx_o = res;
        end
      end
      K_OR:    acc_nx_o = acc_i | opnd;
      K_AND:   acc_nx_o = acc_i & opnd;
      K_XOR:   acc_nx_o = acc_i ^ opnd;
      K_NOT:   acc_nx_o = ~acc_i;
      default: acc_nx_o = acc_i;
    endcase
  end

endmodule

// File: rtl/accu_alu_carryhist.sv
module accu_alu_carryhist #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  input  logic carry_i,
  output logic carry_o
);

  logic [LAG-1:0] hist_q;

  generate
    if (LAG == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)        hist_q <= '0;
        else if (adv_i) hist_q <= carry_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)        hist_q <= '0;
        else if (adv_i) hist_q <= {hist_q[LAG-2:0], carry_i};
      end
    end
  endgenerate

  assign carry_o = hist_q[LAG-1];

endmodule

// File: rtl/accu_alu.sv
module accu_alu
  import accu_alu_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int SEL_W     = 3,
  parameter int CARRY_LAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [4:0]       opcode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] reg_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] acc_o,
  output logic             wb_en_o,
  output logic [SEL_W-1:0] wb_sel_o,
  output logic [WIDTH-1:0] wb_data_o,
  output logic             flag_c_o,
  output logic             flag_s_o,
  output logic             flag_z_o,
  output logic             flag_u_o
);

  ctrl_t            ctrl;
  logic             zsel, hist_c;
  logic [WIDTH-1:0] acc_nx, wb_nx;
  logic             wb_en_nx, c_nx, u_nx;

  assign zsel = (sel_i == '0);

  accu_alu_opdec #(.SEL_W(SEL_W)) dec_i (
    .opcode_i (opcode_i),
    .sel_i    (sel_i),
    .ctrl_o   (ctrl)
  );

  accu_alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .ctrl_i       (ctrl),
    .zsel_i       (zsel),
    .acc_i        (acc_i),
    .reg_i        (reg_i),
    .hist_carry_i (hist_c),
    .acc_nx_o     (acc_nx),
    .wb_nx_o      (wb_nx),
    .wb_en_nx_o   (wb_en_nx),
    .c_nx_o       (c_nx),
    .u_nx_o       (u_nx)
  );

  accu_alu_carryhist #(.LAG(CARRY_LAG)) ch_i (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (valid_i),
    .carry_i (c_nx),
    .carry_o (hist_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      wb_en_o   <= 1'b0;
      acc_o     <= '0;
      wb_sel_o  <= '0;
      wb_data_o <= '0;
      flag_c_o  <= 1'b0;
      flag_s_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_u_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      wb_en_o <= valid_i & wb_en_nx;
      if (valid_i) begin
        acc_o     <= acc_nx;
        wb_sel_o  <= sel_i;
        wb_data_o <= wb_nx;
        flag_c_o  <= c_nx;
        flag_s_o  <= acc_nx[WIDTH-1];
        flag_z_o  <= (acc_nx == '0);
        flag_u_o  <= u_nx;
      end
    end
  end

  // R2: writeback only accompanies a result
  a_r2_wb_with_valid: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> valid_o);

  // R2: idle cycle leaves accumulator and flags untouched
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(acc_o) && $stable(flag_c_o) && $stable(flag_z_o)
                  && $stable(flag_s_o) && $stable(flag_u_o) && !wb_en_o));

  // R4: the zero register is never written
  a_r4_no_zero_wb: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> (wb_sel_o != '0));

  // R3: move into accumulator, clear for select 0
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (valid_i && opcode_i == OP_LOAD) |=>
      (acc_o == (($past(sel_i) == '0) ? '0 : $past(reg_i))));

  // R5: store to the zero register is a no-operation
  a_r5_store_zero_nop: assert property (@(posedge clk) disable iff (rst)
    (valid_i && opcode_i == OP_STORE && sel_i == '0) |=>
      (!wb_en_o && acc_o == $past(acc_i)));

  // R10: accumulator complement
  a_r10_not: assert property (@(posedge clk) disable iff (rst)
    (valid_i && opcode_i == OP_MISC && sel_i == SEL_W'(MISC_NOT_SEL)) |=>
      (acc_o == ~$past(acc_i)));

  // R11: zero flag tracks the accumulator, borrow excludes carry
  a_r11_zero_flag: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (flag_z_o == (acc_o == '0)));
  a_r11_borrow_no_carry: assert property (@(posedge clk) disable iff (rst)
    flag_u_o |-> !flag_c_o);

endmodule

// File: tb/accu_alu_tb_top.sv
module accu_alu_tb_top;

  localparam logic [4:0] T_MISC = 5'h00, T_LOAD = 5'h01, T_XCHG = 5'h02,
    T_STG = 5'h03, T_STORE = 5'h04, T_INC = 5'h05, T_DEC = 5'h06,
    T_NEG = 5'h07, T_RSH = 5'h08, T_ADD = 5'h09, T_ADDC = 5'h0A,
    T_SUB = 5'h0B, T_SUBB = 5'h0C, T_OR = 5'h0D, T_AND = 5'h0E, T_XOR = 5'h0F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       valid_i = 1'b0;
  logic [4:0] opcode_i = '0;
  logic [2:0] sel_i = '0;
  logic [7:0] acc_i = '0, reg_i = '0;
  logic       valid_o, wb_en_o, flag_c_o, flag_s_o, flag_z_o, flag_u_o;
  logic [7:0] acc_o, wb_data_o;
  logic [2:0] wb_sel_o;

  always #10 clk = ~clk;  // 50 MHz

  accu_alu dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i),
    .sel_i(sel_i), .acc_i(acc_i), .reg_i(reg_i), .valid_o(valid_o),
    .acc_o(acc_o), .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o),
    .wb_data_o(wb_data_o), .flag_c_o(flag_c_o), .flag_s_o(flag_s_o),
    .flag_z_o(flag_z_o), .flag_u_o(flag_u_o)
  );

  typedef struct {
    logic [7:0] acc;
    logic       wb_en;
    logic [7:0] wb;
    logic [2:0] sel;
    logic [3:0] flags;  // {c, s, z, u}
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic cy1 = 1'b0, cy2 = 1'b0;  // carry one and two instructions back
  logic [7:0] last_acc = '0;
  logic [3:0] last_flags = '0;

  task automatic issue(input logic [4:0] op, input logic [2:0] sel,
                       input logic [7:0] acc, input logic [7:0] rg,
                       input string tag);
    exp_t e;
    int   full;
    logic zs;
    logic [7:0] x;
    logic c, u;
    zs = (sel == 3'd0);
    x  = zs ? acc : rg;
    c  = 1'b0; u = 1'b0;
    e.acc = acc; e.wb_en = 1'b0; e.wb = 8'h00; e.sel = sel; e.tag = tag;
    case (op)
      T_MISC:  if (sel == 3'd3) e.acc = ~acc;
      T_LOAD:  e.acc = zs ? 8'h00 : rg;
      T_XCHG:  begin e.acc = zs ? 8'h00 : rg; e.wb_en = !zs; e.wb = acc; end
      T_STORE: begin e.wb_en = !zs; e.wb = acc; end
      T_INC, T_DEC, T_NEG, T_RSH: begin
        logic [7:0] r;
        case (op)
          T_INC:   begin full = int'(x) + 1; c = (full > 255); end
          T_DEC:   begin full = int'(x) - 1; u = (full < 0); c = !u; end
          T_NEG:   begin full = 0 - int'(x); u = (full < 0); c = !u; end
          default: full = int'(x) / 2;
        endcase
        r = full[7:0];
        if (zs) e.acc = r;
        else begin e.wb_en = 1'b1; e.wb = r; end
      end
      T_ADD:  begin full = int'(acc) + int'(x); c = (full > 255); e.acc = full[7:0]; end
      T_ADDC: begin
        full = int'(acc) + (zs ? 0 : int'(rg)) + int'(cy2);
        c = (full > 255); e.acc = full[7:0];
      end
      T_SUB:  begin full = int'(acc) - int'(x); u = (full < 0); c = !u; e.acc = full[7:0]; end
      T_SUBB: begin
        if (zs) begin
          full = int'(acc) + 255 + int'(cy2); c = (full > 255); u = !c;
        end else begin
          full = int'(acc) - int'(rg) - 1 + int'(cy2); u = (full < 0); c = !u;
        end
        e.acc = full[7:0];
      end
      T_OR:   e.acc = acc | x;
      T_AND:  e.acc = acc & x;
      T_XOR:  e.acc = acc ^ x;
      default: ;
    endcase
    e.flags = {c, e.acc[7], (e.acc == 8'h00), u};
    cy2 = cy1; cy1 = c;
    last_acc = e.acc; last_flags = e.flags;
    @(negedge clk);
    valid_i = 1'b1; opcode_i = op; sel_i = sel; acc_i = acc; reg_i = rg;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    acc_i = 8'hA5; reg_i = 8'h5A; opcode_i = T_XOR; sel_i = 3'd0;
  endtask

  task automatic check_idle(input string tag);
    idle(); idle();
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || wb_en_o !== 1'b0 || acc_o !== last_acc ||
        {flag_c_o, flag_s_o, flag_z_o, flag_u_o} !== last_flags) begin
      errors++;
      $display("FAIL %s idle: valid=%b wb_en=%b acc=%h flags=%b exp acc=%h flags=%b",
               tag, valid_o, wb_en_o, acc_o,
               {flag_c_o, flag_s_o, flag_z_o, flag_u_o}, last_acc, last_flags);
    end
  endtask

  task automatic do_reset();
    idle(); idle();
    rst = 1'b1;
    idle(); idle();
    rst = 1'b0;
    cy1 = 1'b0; cy2 = 1'b0; last_acc = '0; last_flags = '0;
  endtask

  // monitor: compare each result against the oldest expectation
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected result acc=%h expected no result", acc_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (acc_o !== e.acc || wb_en_o !== e.wb_en ||
            {flag_c_o, flag_s_o, flag_z_o, flag_u_o} !== e.flags ||
            (e.wb_en && (wb_data_o !== e.wb || wb_sel_o !== e.sel))) begin
          errors++;
          $display("FAIL %s acc=%h wb_en=%b wb=%h sel=%0d csz u=%b exp acc=%h wb_en=%b wb=%h sel=%0d csz u=%b",
                   e.tag, acc_o, wb_en_o, wb_data_o, wb_sel_o,
                   {flag_c_o, flag_s_o, flag_z_o, flag_u_o},
                   e.acc, e.wb_en, e.wb, e.sel, e.flags);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1 reset state
    if (acc_o !== 8'h00 || valid_o !== 1'b0 || wb_en_o !== 1'b0 ||
        wb_data_o !== 8'h00 || {flag_c_o, flag_s_o, flag_z_o, flag_u_o} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset acc=%h valid=%b wb_en=%b expected all zero",
               acc_o, valid_o, wb_en_o);
    end

    issue(T_LOAD, 3'd2, 8'h33, 8'h5A, "R3 load");
    issue(T_LOAD, 3'd0, 8'h33, 8'h5A, "R3 load zero-sel clear");
    issue(T_XCHG, 3'd4, 8'h11, 8'h22, "R4 exchange");
    issue(T_XCHG, 3'd0, 8'h11, 8'h22, "R4 exchange zero-sel");
    issue(T_STORE, 3'd5, 8'h77, 8'h01, "R5 store");
    issue(T_STORE, 3'd0, 8'h77, 8'h01, "R5 store zero-sel nop");
    issue(T_INC, 3'd1, 8'h40, 8'hFF, "R6 inc reg wrap");
    issue(T_INC, 3'd0, 8'h7F, 8'h00, "R6 inc acc");
    issue(T_DEC, 3'd6, 8'h10, 8'h00, "R6 dec reg borrow");
    issue(T_DEC, 3'd0, 8'h01, 8'h00, "R6 dec acc to zero");
    issue(T_NEG, 3'd7, 8'h20, 8'h05, "R6 neg reg");
    issue(T_NEG, 3'd0, 8'h00, 8'h05, "R6 neg acc zero");
    issue(T_RSH, 3'd2, 8'hC3, 8'h81, "R6 rsh reg");
    issue(T_RSH, 3'd0, 8'hC3, 8'h81, "R6 rsh acc");
    check_idle("R2 hold after unary");

    issue(T_ADD, 3'd1, 8'hF0, 8'h20, "R7 add carry out");
    issue(T_SUB, 3'd1, 8'h10, 8'h20, "R7 sub borrow");
    issue(T_ADD, 3'd0, 8'h40, 8'h99, "R7 add zero-sel doubles acc");
    issue(T_SUB, 3'd0, 8'h40, 8'h99, "R7 sub zero-sel");
    issue(T_SUB, 3'd3, 8'h80, 8'h01, "R11 sub no borrow sign");

    // R8/R12: carry from two back differs from the previous one
    issue(T_ADD, 3'd1, 8'hFF, 8'h01, "R8 setup carry");
    issue(T_OR,  3'd1, 8'h00, 8'h00, "R12 non-arith pushes zero carry");
    issue(T_ADDC, 3'd1, 8'h00, 8'h00, "R8 addc uses carry two back");
    issue(T_ADDC, 3'd1, 8'h00, 8'h00, "R8 addc sees OR carry zero");
    issue(T_SUB, 3'd1, 8'h05, 8'h03, "R8 sub no borrow");
    issue(T_AND, 3'd1, 8'hFF, 8'hFF, "R12 filler");
    issue(T_SUBB, 3'd1, 8'h05, 8'h03, "R8 subb carry set");
    issue(T_SUBB, 3'd1, 8'h05, 8'h03, "R8 subb carry clear");
    issue(T_ADD, 3'd1, 8'h80, 8'h80, "R8 setup carry zero-sel");
    issue(T_XOR, 3'd1, 8'h00, 8'h00, "R12 filler zero-sel");
    issue(T_ADDC, 3'd0, 8'h10, 8'h00, "R8 addc zero-sel adds carry");
    issue(T_SUBB, 3'd0, 8'h10, 8'h00, "R8 subb zero-sel ones operand");
    issue(T_SUBB, 3'd0, 8'h00, 8'h00, "R8 subb zero-sel no carry");

    issue(T_OR,  3'd2, 8'h0F, 8'hF0, "R9 or");
    issue(T_AND, 3'd2, 8'h3C, 8'h0F, "R9 and");
    issue(T_XOR, 3'd2, 8'h3C, 8'hFF, "R9 xor");
    issue(T_XOR, 3'd0, 8'h3C, 8'hFF, "R9 xor zero-sel clears");
    issue(T_OR,  3'd0, 8'h96, 8'h00, "R9 or zero-sel keeps");
    issue(T_MISC, 3'd3, 8'h0F, 8'h00, "R10 not");
    issue(T_MISC, 3'd1, 8'h0F, 8'h00, "R10 misc other sel");
    issue(T_STG, 3'd2, 8'h44, 8'h99, "R10 opcode 03 no effect");
    issue(5'h13, 3'd2, 8'h44, 8'h99, "R10 upper opcode no effect");
    check_idle("R2 hold after logic");

    // R1: reset clears the carry history
    issue(T_ADD, 3'd1, 8'hFF, 8'hFF, "R1 pre-reset carry");
    issue(T_ADD, 3'd1, 8'hFF, 8'hFF, "R1 pre-reset carry");
    do_reset();
    issue(T_ADDC, 3'd1, 8'h00, 8'h00, "R1 carry history cleared");
    check_idle("R2 hold after reset");

    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 %0d results missing, expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule